// File: doc/BRIEF.md
# Register Rename Map and Free List

This block sits between decode and scheduling in an out-of-order core. Each cycle it takes one decoded instruction, turns its architected source register numbers into physical register tags, and gives the destination a fresh physical register taken from a list of unused tags. A map table holds the current architected-to-physical mapping. A first-in, first-out free list holds the physical tags that no architected register owns.

The renamed instruction appears on registered outputs one cycle after it is accepted. The outputs carry the source tags, the immediate (which is not renamed), the new destination tag and the tag the destination was mapped to before. A later stage returns that previous tag through the release port once it is safe to reuse. Giving every write a distinct tag removes write-after-write and write-after-read name conflicts and keeps read-after-write links. When a writing instruction arrives and the list is empty, the block raises stall and changes nothing.

Top module: `rename_unit`

## Requirements
- R1: After reset, architected register i maps to physical tag i for every i below NUM_ARCH.
- R2: After reset, the free list holds tags NUM_ARCH to NUM_PHYS-1 and hands them to successive writers in ascending order.
- R3: Sources are translated with the mapping in force before the same instruction's destination is remapped, including when a source names the destination register.
- R4: An architected register keeps translating to the tag it last received until a later instruction writes it again.
- R5: When in_opb_kind is 1 (immediate), out_opb_kind is 1 and out_opb equals in_imm unchanged. When in_opb_kind is 0 (register), out_opb_kind is 0 and out_opb is the source-B tag zero-extended.
- R6: out_dst_old carries the destination's mapping from before the rename, and out_dst_new carries the allocated tag. Both are 0 when out_has_dst is 0.
- R7: stall is high exactly when in_valid and in_has_dst are high and the free list is empty at the start of the cycle. A release in that same cycle does not lift the stall. A stalled instruction changes neither the map nor the list, and out_valid is low in the next cycle.
- R8: An instruction with in_has_dst low is accepted even when the list is empty, and it consumes no tag.
- R9: A released tag goes to the tail of the free list. A release and an allocation in the same cycle both take effect: the allocation takes the head entry and the released tag queues behind the others.
- R10: out_valid is high in the cycle after an accepted instruction and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_src_a | input | ARCH_W | Architected source A |
| in_opb_kind | input | 1 | 0: operand B is a register, 1: an immediate |
| in_src_b | input | ARCH_W | Architected source B |
| in_imm | input | IMM_W | Immediate value |
| in_has_dst | input | 1 | Instruction writes a register |
| in_dst | input | ARCH_W | Architected destination |
| rel_valid | input | 1 | Return a tag to the free list |
| rel_tag | input | PHYS_W | Tag being returned |
| stall | output | 1 | Instruction cannot be accepted this cycle |
| out_valid | output | 1 | Renamed instruction present |
| out_src_a | output | PHYS_W | Physical source A |
| out_opb_kind | output | 1 | Operand B kind, passed through |
| out_opb | output | IMM_W | Physical source B or the immediate |
| out_has_dst | output | 1 | Renamed instruction writes a register |
| out_dst_new | output | PHYS_W | Newly allocated destination tag |
| out_dst_old | output | PHYS_W | Previous mapping of the destination |

## Verification
The bench uses the default build of four architected and eight physical registers, so the free list is four entries deep. At that size the bench can sweep all 64 combinations of source A, source B and destination, including every case where a source and the destination are the same register. It can also drain the list to empty in four writes and observe stall, a non-writing instruction going through while the list is empty, and a release arriving in the same cycle as an allocation, both on an empty list and on a non-empty one. Expected tags come from a map array and a queue kept in the bench.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

    // operand B selector encoding
    localparam logic OPB_REG = 1'b0;
    localparam logic OPB_IMM = 1'b1;

    // circular pointer advance for a ring of n slots
    function automatic int unsigned ring_next(input int unsigned p, input int unsigned n);
        return (p + 1 == n) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
    parameter int NUM_ARCH = 4,
    parameter int NUM_PHYS = 8,
    localparam int ARCH_W = $clog2(NUM_ARCH),
    localparam int PHYS_W = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ARCH_W-1:0] rd_a_idx,
    input  logic [ARCH_W-1:0] rd_b_idx,
    input  logic [ARCH_W-1:0] rd_d_idx,
    output logic [PHYS_W-1:0] rd_a,
    output logic [PHYS_W-1:0] rd_b,
    output logic [PHYS_W-1:0] rd_d,
    input  logic              wr_en,
    input  logic [ARCH_W-1:0] wr_idx,
    input  logic [PHYS_W-1:0] wr_tag
);

    logic [PHYS_W-1:0] map_q [NUM_ARCH];

    for (genvar i = 0; i < NUM_ARCH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                map_q[i] <= PHYS_W'(i);
            end else if (wr_en && (wr_idx == ARCH_W'(i))) begin
                map_q[i] <= wr_tag;
            end
        end
    end

    // reads see the registered state, so a same-cycle write is not visible
    always_comb begin
        rd_a = map_q[rd_a_idx];
        rd_b = map_q[rd_b_idx];
        rd_d = map_q[rd_d_idx];
    end

endmodule

// File: rtl/rnm_free_list.sv
module rnm_free_list #(
    parameter int DEPTH  = 4,
    parameter int BASE   = 4,
    parameter int TAG_W  = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    output logic [TAG_W-1:0] pop_tag,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    output logic [CNT_W-1:0] count,
    output logic             empty
);
    import rnm_pkg::*;

    logic [TAG_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pop_ok, push_ok;

    assign empty   = (cnt_q == '0);
    assign count   = cnt_q;
    assign pop_tag = slot_q[head_q];
    assign pop_ok  = pop && !empty;
    assign push_ok = push && ((cnt_q != CNT_W'(DEPTH)) || pop_ok);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= TAG_W'(BASE + i);
            end else if (push_ok && (tail_q == PTR_W'(i))) begin
                slot_q[i] <= push_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= CNT_W'(DEPTH);
        end else begin
            if (pop_ok) begin
                head_q <= PTR_W'(ring_next(int'(head_q), DEPTH));
            end
            if (push_ok) begin
                tail_q <= PTR_W'(ring_next(int'(tail_q), DEPTH));
            end
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int NUM_ARCH = 4,
    parameter int NUM_PHYS = 8,
    parameter int IMM_W    = 8,
    localparam int ARCH_W  = $clog2(NUM_ARCH),
    localparam int PHYS_W  = $clog2(NUM_PHYS),
    localparam int FL_DEPTH = NUM_PHYS - NUM_ARCH,
    localparam int CNT_W   = $clog2(FL_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ARCH_W-1:0] in_src_a,
    input  logic              in_opb_kind,
    input  logic [ARCH_W-1:0] in_src_b,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic              in_has_dst,
    input  logic [ARCH_W-1:0] in_dst,
    input  logic              rel_valid,
    input  logic [PHYS_W-1:0] rel_tag,
    output logic              stall,
    output logic              out_valid,
    output logic [PHYS_W-1:0] out_src_a,
    output logic              out_opb_kind,
    output logic [IMM_W-1:0]  out_opb,
    output logic              out_has_dst,
    output logic [PHYS_W-1:0] out_dst_new,
    output logic [PHYS_W-1:0] out_dst_old
);
    import rnm_pkg::*;

    logic [PHYS_W-1:0] map_a, map_b, map_d, fresh_tag;
    logic [CNT_W-1:0]  fl_count;
    logic              fl_empty, accept, alloc;

    assign stall  = in_valid && in_has_dst && fl_empty;
    assign accept = in_valid && !stall;
    assign alloc  = accept && in_has_dst;

    rnm_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (in_src_a),
        .rd_b_idx (in_src_b),
        .rd_d_idx (in_dst),
        .rd_a     (map_a),
        .rd_b     (map_b),
        .rd_d     (map_d),
        .wr_en    (alloc),
        .wr_idx   (in_dst),
        .wr_tag   (fresh_tag)
    );

    rnm_free_list #(.DEPTH(FL_DEPTH), .BASE(NUM_ARCH), .TAG_W(PHYS_W)) u_fl (
        .clk      (clk),
        .rst      (rst),
        .pop      (alloc),
        .pop_tag  (fresh_tag),
        .push     (rel_valid),
        .push_tag (rel_tag),
        .count    (fl_count),
        .empty    (fl_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_src_a    <= '0;
            out_opb_kind <= OPB_REG;
            out_opb      <= '0;
            out_has_dst  <= 1'b0;
            out_dst_new  <= '0;
            out_dst_old  <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_src_a    <= map_a;
                out_opb_kind <= in_opb_kind;
                out_opb      <= (in_opb_kind == OPB_IMM) ? in_imm : IMM_W'(map_b);
                out_has_dst  <= in_has_dst;
                out_dst_new  <= in_has_dst ? fresh_tag : '0;
                out_dst_old  <= in_has_dst ? map_d : '0;
            end
        end
    end

endmodule

// File: rtl/rnm_chk.sv
module rnm_chk #(
    parameter int ARCH_W = 2,
    parameter int PHYS_W = 3,
    parameter int IMM_W  = 8,
    parameter int FL_DEPTH = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_has_dst,
    input logic              in_opb_kind,
    input logic [IMM_W-1:0]  in_imm,
    input logic              rel_valid,
    input logic              stall,
    input logic              out_valid,
    input logic              out_opb_kind,
    input logic [IMM_W-1:0]  out_opb,
    input logic              out_has_dst,
    input logic [PHYS_W-1:0] out_dst_new,
    input logic [PHYS_W-1:0] out_dst_old,
    input logic [CNT_W-1:0]  fl_count
);

    // R7
    stall_blocks_out_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> !out_valid);

    // R7
    stall_keeps_list_chk: assert property (@(posedge clk) disable iff (rst)
        (stall && !rel_valid) |=> (fl_count == $past(fl_count)));

    // R10
    accept_emits_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !stall) |=> out_valid);

    // R8
    nodst_never_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_has_dst) |-> !stall);

    // R5
    imm_passes_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !stall && in_opb_kind) |=> (out_opb_kind && out_opb == $past(in_imm)));

    // R6
    fresh_differs_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_has_dst) |-> (out_dst_new != out_dst_old));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        rel_valid |-> ((fl_count < CNT_W'(FL_DEPTH)) || (in_valid && in_has_dst && !stall)));

endmodule

bind rename_unit rnm_chk #(
    .ARCH_W(ARCH_W), .PHYS_W(PHYS_W), .IMM_W(IMM_W), .FL_DEPTH(FL_DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_has_dst(in_has_dst),
    .in_opb_kind(in_opb_kind), .in_imm(in_imm), .rel_valid(rel_valid),
    .stall(stall), .out_valid(out_valid), .out_opb_kind(out_opb_kind),
    .out_opb(out_opb), .out_has_dst(out_has_dst), .out_dst_new(out_dst_new),
    .out_dst_old(out_dst_old), .fl_count(fl_count)
);

// File: tb/sim_rename_unit.sv
`timescale 1ns/1ps
module sim_rename_unit;
    localparam int NA = 4, NP = 8, IW = 8;
    localparam int AW = 2, PW = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 0, in_opb_kind = 0, in_has_dst = 0, rel_valid = 0;
    logic [AW-1:0] in_src_a = 0, in_src_b = 0, in_dst = 0;
    logic [IW-1:0] in_imm = 0;
    logic [PW-1:0] rel_tag = 0;
    logic stall, out_valid, out_opb_kind, out_has_dst;
    logic [PW-1:0] out_src_a, out_dst_new, out_dst_old;
    logic [IW-1:0] out_opb;

    always #2 clk = ~clk;

    rename_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP), .IMM_W(IW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_src_a(in_src_a),
        .in_opb_kind(in_opb_kind), .in_src_b(in_src_b), .in_imm(in_imm),
        .in_has_dst(in_has_dst), .in_dst(in_dst), .rel_valid(rel_valid),
        .rel_tag(rel_tag), .stall(stall), .out_valid(out_valid),
        .out_src_a(out_src_a), .out_opb_kind(out_opb_kind), .out_opb(out_opb),
        .out_has_dst(out_has_dst), .out_dst_new(out_dst_new), .out_dst_old(out_dst_old)
    );

    int total = 0, bad = 0;
    bit finished = 0;
    int mdl_map [NA];
    int mdl_fq [$];
    int olds [$];

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one instruction plus an optional release; checks stall and the registered result
    task automatic do_op(input string req, input int a, input bit bimm, input int b, input int imm,
                         input bit hd, input int d, input bit fv, input int ft);
        bit exp_stall, acc;
        int ea, eb, en, eo;
        @(negedge clk);
        in_valid = 1; in_src_a = AW'(a); in_opb_kind = bimm; in_src_b = AW'(b);
        in_imm = IW'(imm); in_has_dst = hd; in_dst = AW'(d);
        rel_valid = fv; rel_tag = PW'(ft);
        #1;
        exp_stall = hd && (mdl_fq.size() == 0);
        acc = !exp_stall;
        check(req, "stall", int'(stall), int'(exp_stall));
        ea = mdl_map[a];
        eb = bimm ? imm : mdl_map[b];
        en = 0; eo = 0;
        if (acc && hd) begin
            en = mdl_fq.pop_front();
            eo = mdl_map[d];
            mdl_map[d] = en;
            olds.push_back(eo);
        end
        if (fv) mdl_fq.push_back(ft);
        @(posedge clk); #1;
        in_valid = 0; rel_valid = 0;
        check(req, "out_valid", int'(out_valid), int'(acc));
        if (acc) begin
            check(req, "out_src_a", int'(out_src_a), ea);
            check(req, "out_opb_kind", int'(out_opb_kind), int'(bimm));
            check(req, "out_opb", int'(out_opb), eb);
            check(req, "out_has_dst", int'(out_has_dst), int'(hd));
            check(req, "out_dst_new", int'(out_dst_new), en);
            check(req, "out_dst_old", int'(out_dst_old), eo);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NA; i++) mdl_map[i] = i;
        for (int i = NA; i < NP; i++) mdl_fq.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        // reset state
        check("R10", "reset out_valid", int'(out_valid), 0);
        check("R7", "reset stall", int'(stall), 0);

        // R1: identity map seen by sources, no write
        do_op("R1", 1, 0, 2, 0, 0, 0, 0, 0);
        do_op("R1", 3, 0, 0, 0, 0, 0, 0, 0);
        // R2: four writers receive ascending free tags; R3 source equals destination
        do_op("R2", 2, 0, 3, 0, 1, 1, 0, 0);
        do_op("R3", 2, 0, 1, 0, 1, 2, 0, 0);
        do_op("R3", 1, 0, 3, 0, 1, 3, 0, 0);
        // R4: earlier mapping persists for unwritten register
        do_op("R4", 1, 0, 2, 0, 1, 1, 0, 0);
        // R7: list now empty, writer stalls and changes nothing
        do_op("R7", 1, 0, 2, 0, 1, 0, 0, 0);
        // R8: non-writer accepted while empty, R5 immediate
        do_op("R8", 3, 1, 0, 8'hA5, 0, 0, 0, 0);
        // R7: release arriving with a stalled writer does not lift the stall
        do_op("R7", 0, 0, 1, 0, 1, 0, 1, olds.pop_front());
        // R9: released tag now allocated
        do_op("R9", 0, 1, 0, 8'hFF, 1, 0, 0, 0);
        // R9: give back the rest, then allocate and release together
        while (olds.size() > 1) do_op("R9", 0, 0, 0, 0, 0, 0, 1, olds.pop_front());
        do_op("R9", 2, 0, 1, 0, 1, 2, 1, olds.pop_front());
        do_op("R6", 3, 1, 0, 0, 1, 3, 1, olds.pop_front());

        // R3 R4 R5 R6 R9: sweep every source/destination combination, releasing
        // each previous mapping one instruction later
        for (int a = 0; a < NA; a++)
            for (int b = 0; b < NA; b++)
                for (int d = 0; d < NA; d++) begin
                    bit useimm = ((a + b + d) % 3 == 0);
                    bit fv = (olds.size() > 0);
                    int ft = fv ? olds.pop_front() : 0;
                    do_op("R3", a, useimm, b, (a * 16 + b * 4 + d) ^ 8'h5A, 1, d, fv, ft);
                end
        while (olds.size() > 0) do_op("R9", 0, 0, 0, 0, 0, 0, 1, olds.pop_front());
        // idle cycle: R10 no spurious output
        @(negedge clk); @(posedge clk); #1;
        check("R10", "idle out_valid", int'(out_valid), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule